// File: doc/BRIEF.md
# Charger Status and Configuration Register File

This block is the register side of a serially controlled battery charger. A bus slave, which sits outside the block, turns serial transfers into single-cycle read and write strobes with an address and a data byte. The block decodes those strobes against a small sparse register space. The space holds one status register, a bank of five charger configuration registers, an unlock register and a non-volatile-memory program register. The configuration bank is presented in parallel to the charger core.

Eight level event inputs from the charger core set sticky bits in the status register. A read of that register clears them. The upper four bits are faults: any of them drives an active-low fault output that stays asserted until software reads the status register. The lower four bits are warnings: they are recorded but never touch the pin.

The configuration bank and the program register are reachable only while the unlock bit is set. A write of 1 to bit 0 of the program register, made while unlocked, emits a one-cycle request to copy the bank into non-volatile memory.

Top module: `chg_regfile`

## Requirements
- R1: After a synchronous reset: the status register reads 0x00, fault_n is 1, ee_prog_req is 0, the unlock register reads 0x00, reg_rdata is 0x00, and cfg_q equals the CFG_RESET parameter.
- R2: Status bit i is set in the cycle after evt_in[i] is high. It stays set after the event ends, until status (address 0x00) is read. The bit order from bit 7 down to bit 0 is: battery over-voltage, full-charge timer expired, battery too cold, battery too hot, die over-temperature, top-off timer expired, input under-voltage, thermistor open.
- R3: An event on any of bits 7..4 (faults) drives fault_n to 0 in the cycle after the event. Events on bits 3..0 (warnings) leave fault_n at 1.
- R4: fault_n stays 0 after the fault event ends, and returns to 1 in the cycle after a read of address 0x00, provided no fault event is active during that read.
- R5: A read of address 0x00 returns the status bits as they stood before the read and clears every bit not re-set by an event in that same cycle.
- R6: An event still high during the clearing read sets its bit again, so a following read returns it, and fault_n stays 0 if that bit is a fault.
- R7: The configuration registers at addresses 0x02..0x06 (bank index = address - 0x02, appearing at cfg_q[index*8 +: 8]) are written and read back only while unlock bit 0 is 1. While locked, writes leave cfg_q unchanged and reads return 0x00. The contents are kept across lock and unlock.
- R8: The unlock register at 0x11 is always accessible. Bit 0 is read/write, and bits 7..1 read 0.
- R9: A write to address 0x12 with bit 0 = 1 while unlocked gives ee_prog_req = 1 for exactly one cycle, the cycle after the write. While locked it gives no pulse and the register reads 0x00. While unlocked, bit 0 reads back the last value written.
- R10: Unimplemented addresses (0x01, 0x07..0x10, 0x13 and above) read 0x00 and ignore writes. Writes to the status register are ignored.
- R11: reg_rdata is loaded in the cycle after a reg_rd strobe and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| evt_in | input | DW | Level event inputs, one per status bit |
| fault_n | output | 1 | Active-low sticky fault indication (open-drain pin model) |
| ee_prog_req | output | 1 | One-cycle request to program non-volatile memory from the bank |
| cfg_q | output | NCFG*DW | Configuration bank contents, index 0 in the low byte |

## Verification
The bench keeps the default widths, bank size and address map. It sets CFG_RESET to a distinct byte per bank entry (0x81, 0x0F, 0x96, 0x3C, 0xA5 from index 0 up). This makes a wrong bank index or a lost reset value visible both on cfg_q and in read-back. With the default eight-bit status, each of the four fault positions and the warning nibble can be driven separately. This exposes any pin that follows a warning, or one that releases before the clearing read.

// File: rtl/chg_regs_pkg.sv
package chg_regs_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int N_CFG   = 5;
  localparam int N_FAULT = 4;

  localparam logic [7:0] A_STATUS    = 8'h00;
  localparam logic [7:0] A_CFG_FIRST = 8'h02;
  localparam logic [7:0] A_UNLOCK    = 8'h11;
  localparam logic [7:0] A_EEPROG    = 8'h12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_CFG,
    SEL_UNLOCK,
    SEL_EE
  } sel_e;
endpackage

// File: rtl/chg_status.sv
module chg_status #(
  parameter int W  = 8,
  parameter int NF = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] st_q,
  output logic         fault_n
);
  logic [W-1:0] st_n;

  // A clearing read drops the old bits, but events of the same cycle survive.
  always_comb st_n = (clr ? '0 : st_q) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      fault_n <= 1'b1;
    end else begin
      st_q    <= st_n;
      fault_n <= ~(|st_n[W-1 -: NF]);
    end
  end
endmodule

// File: rtl/chg_cfg_bank.sv
module chg_cfg_bank #(
  parameter int               W   = 8,
  parameter int               N   = 5,
  parameter logic [N*W-1:0]   RST = '0,
  localparam int              IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [N*W-1:0] flat
);
  logic [W-1:0] bank [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        bank[i] <= RST[i*W +: W];
      else if (we && idx == IW'(i))
        bank[i] <= wdata;
    end
    assign flat[i*W +: W] = bank[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (idx == IW'(i)) rdata = bank[i];
  end
endmodule

// File: rtl/chg_regfile.sv
module chg_regfile
  import chg_regs_pkg::*;
#(
  parameter int                  DW        = DATA_W,
  parameter int                  AW        = ADDR_W,
  parameter int                  NCFG      = N_CFG,
  parameter int                  NFLT      = N_FAULT,
  parameter logic [NCFG*DW-1:0]  CFG_RESET = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [DW-1:0]      evt_in,
  output logic               fault_n,
  output logic               ee_prog_req,
  output logic [NCFG*DW-1:0] cfg_q
);
  localparam int IW = (NCFG > 1) ? $clog2(NCFG) : 1;

  logic [DW-1:0] st_q;
  logic [DW-1:0] cfg_rd;
  logic [AW-1:0] cfg_off;
  logic          in_cfg;
  logic          unlock_q;
  logic          ee_q;
  sel_e          sel;
  logic [DW-1:0] rd_mux;

  assign cfg_off = reg_addr - AW'(A_CFG_FIRST);
  assign in_cfg  = cfg_off < AW'(NCFG);

  always_comb begin
    if (reg_addr == AW'(A_STATUS))                 sel = SEL_STATUS;
    else if (in_cfg && unlock_q)                   sel = SEL_CFG;
    else if (reg_addr == AW'(A_UNLOCK))            sel = SEL_UNLOCK;
    else if (reg_addr == AW'(A_EEPROG) && unlock_q) sel = SEL_EE;
    else                                           sel = SEL_NONE;
  end

  chg_status #(.W(DW), .NF(NFLT)) u_status (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_in),
    .clr     (reg_rd && sel == SEL_STATUS),
    .st_q    (st_q),
    .fault_n (fault_n)
  );

  chg_cfg_bank #(.W(DW), .N(NCFG), .RST(CFG_RESET)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_wr && sel == SEL_CFG),
    .idx   (cfg_off[IW-1:0]),
    .wdata (reg_wdata),
    .rdata (cfg_rd),
    .flat  (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q    <= 1'b0;
      ee_q        <= 1'b0;
      ee_prog_req <= 1'b0;
    end else begin
      if (reg_wr && sel == SEL_UNLOCK) unlock_q <= reg_wdata[0];
      if (reg_wr && sel == SEL_EE)     ee_q     <= reg_wdata[0];
      ee_prog_req <= reg_wr && sel == SEL_EE && reg_wdata[0];
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = st_q;
      SEL_CFG:    rd_mux = cfg_rd;
      SEL_UNLOCK: rd_mux = {{(DW-1){1'b0}}, unlock_q};
      SEL_EE:     rd_mux = {{(DW-1){1'b0}}, ee_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/chg_regfile_chk.sv
module chg_regfile_chk #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NCFG = 5,
  parameter int NFLT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic [DW-1:0]      evt_in,
  input logic               fault_n,
  input logic               ee_prog_req,
  input logic [NCFG*DW-1:0] cfg_q,
  input logic [DW-1:0]      st_q,
  input logic               unlock_q
);
  localparam logic [AW-1:0] STAT_A = '0;
  localparam logic [AW-1:0] EE_A   = AW'(8'h12);

  // R2: bits stay set unless the status register is read
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_addr == STAT_A) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R3: a fault event pulls the pin low next cycle
  a_r3_fault_low: assert property (@(posedge clk) disable iff (rst)
    (|evt_in[DW-1 -: NFLT]) |=> !fault_n);

  // R4: the pin is released only by a status read
  a_r4_release_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> $past(reg_rd && reg_addr == STAT_A));

  // R5: a read with no events leaves the register empty
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == STAT_A && evt_in == '0) |=> (st_q == '0));

  // R7: writes while locked do not change the bank
  a_r7_locked_stable: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !unlock_q) |=> $stable(cfg_q));

  // R9: the request is a single-cycle pulse caused by a program write
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ee_prog_req |=> !ee_prog_req);

  a_r9_cause: assert property (@(posedge clk) disable iff (rst)
    ee_prog_req |-> $past(reg_wr && reg_addr == EE_A && reg_wdata[0] && unlock_q));
endmodule

bind chg_regfile chg_regfile_chk #(.DW(DW), .AW(AW), .NCFG(NCFG), .NFLT(NFLT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .evt_in      (evt_in),
  .fault_n     (fault_n),
  .ee_prog_req (ee_prog_req),
  .cfg_q       (cfg_q),
  .st_q        (st_q),
  .unlock_q    (unlock_q)
);

// File: tb/chg_regfile_test.sv
`timescale 1ns/1ps
module chg_regfile_test;
  localparam logic [39:0] CRST = 40'hA5_3C_96_0F_81;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  evt_in = '0;
  logic        fault_n;
  logic        ee_prog_req;
  logic [39:0] cfg_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  chg_regfile #(.CFG_RESET(CRST)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .fault_n(fault_n), .ee_prog_req(ee_prog_req), .cfg_q(cfg_q)
  );

  // Monitor: compares read data one cycle after each read strobe.
  always @(posedge clk) rd_pend <= reg_rd;

  always @(negedge clk) begin
    if (rd_pend) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL read with no expectation: actual %02h", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Driver: pushes the expected value, then issues the read.
  task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] shadow;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 fault_n", fault_n, 1);
    check("R1 ee_prog_req", ee_prog_req, 0);
    check("R1 cfg_q", cfg_q, CRST);
    check("R1 rdata", reg_rdata, 0);
    rd_reg(8'h00, 8'h00, "R1 status");
    rd_reg(8'h11, 8'h00, "R1 unlock");

    // R7 locked access
    rd_reg(8'h02, 8'h00, "R7 locked read");
    wr_reg(8'h03, 8'h55);
    check("R7 locked write", cfg_q, CRST);

    // R8 unlock register
    wr_reg(8'h11, 8'hFF);
    rd_reg(8'h11, 8'h01, "R8 unlock readback");
    rd_reg(8'h02, 8'h81, "R7 reset value via read");

    // R7 writable bank
    shadow = CRST;
    for (int i = 0; i < 5; i++) begin
      wr_reg(8'(8'h02 + i), 8'(8'h10 + i * 8'h11));
      shadow[i*8 +: 8] = 8'(8'h10 + i * 8'h11);
    end
    check("R7 cfg_q after writes", cfg_q, shadow);
    for (int i = 0; i < 5; i++)
      rd_reg(8'(8'h02 + i), 8'(8'h10 + i * 8'h11), "R7 readback");

    // R10 unimplemented and status writes
    wr_reg(8'h01, 8'hFF);
    wr_reg(8'h07, 8'hFF);
    wr_reg(8'h10, 8'hFF);
    wr_reg(8'h13, 8'hFF);
    wr_reg(8'h00, 8'hFF);
    check("R10 cfg_q untouched", cfg_q, shadow);
    check("R10 fault_n untouched", fault_n, 1);
    rd_reg(8'h01, 8'h00, "R10 0x01");
    rd_reg(8'h07, 8'h00, "R10 0x07");
    rd_reg(8'h10, 8'h00, "R10 0x10");
    rd_reg(8'h13, 8'h00, "R10 0x13");
    rd_reg(8'h00, 8'h00, "R10 status write ignored");

    // R9 program request
    wr_reg(8'h12, 8'h01);
    check("R9 pulse high", ee_prog_req, 1);
    @(negedge clk);
    check("R9 pulse ends", ee_prog_req, 0);
    rd_reg(8'h12, 8'h01, "R9 readback");
    wr_reg(8'h12, 8'h00);
    check("R9 no pulse on zero", ee_prog_req, 0);

    // R7 lock keeps contents; R9 no pulse while locked
    wr_reg(8'h11, 8'h00);
    wr_reg(8'h12, 8'h01);
    check("R9 locked no pulse", ee_prog_req, 0);
    rd_reg(8'h12, 8'h00, "R9 locked read");
    wr_reg(8'h05, 8'hEE);
    rd_reg(8'h05, 8'h00, "R7 locked read after write");
    check("R7 locked cfg_q", cfg_q, shadow);
    wr_reg(8'h11, 8'h01);
    rd_reg(8'h05, shadow[31:24], "R7 kept across lock");

    // R3 warnings do not touch the pin; R2/R5 sticky and clear
    pulse_evt(8'h0F);
    check("R3 warning pin", fault_n, 1);
    repeat (3) @(negedge clk);
    rd_reg(8'h00, 8'h0F, "R2 warning sticky");
    rd_reg(8'h00, 8'h00, "R5 cleared");

    // R3/R4 each fault bit
    for (int b = 4; b < 8; b++) begin
      pulse_evt(8'(1 << b));
      check("R3 fault low", fault_n, 0);
      repeat (4) @(negedge clk);
      check("R4 still low", fault_n, 0);
      rd_reg(8'h00, 8'(1 << b), "R2 fault bit position");
      check("R4 released after read", fault_n, 1);
    end

    // R6 event held across the clearing read
    evt_in = 8'h20;
    @(negedge clk);
    rd_reg(8'h00, 8'h20, "R6 first read");
    evt_in = 8'h00;
    check("R6 pin held", fault_n, 0);
    rd_reg(8'h00, 8'h20, "R6 bit re-set");
    check("R4 released", fault_n, 1);
    rd_reg(8'h00, 8'h00, "R6 finally clear");

    // R11 rdata holds while idle
    rd_reg(8'h02, shadow[7:0], "R11 load");
    repeat (5) @(negedge clk);
    check("R11 hold", reg_rdata, shadow[7:0]);

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule